// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-facing side of a small asynchronous serial port. A processor reaches it through a simple word bus with four registers: a control word, a receive data port, a transmit data port and a status word. The block turns the control word into the framing settings used by the serial shifters: character length, stop bits, parity style, flow control, enable and loopback. It also holds the enable bits for the DMA request logic, which lives elsewhere.

Writing the transmit port hands one byte to the transmit FIFO. Reading the receive port takes one byte from the receive FIFO, which presents its head byte ahead of the pop. Two sticky pending flags are kept, one for receive and one for transmit. Each is combined with its enable to form a single active-high interrupt level. The status word mixes these flags and two error flags, all cleared by writing ones, with live FIFO and modem-line state and the transmit fill level.

Top module: `sport_regs`

## Requirements
- R1: After reset the control word reads 0 and every pending and error flag in the status word is 0. The interrupt output is low.
- R2: A write to offset 0x00 stores only the defined control bits: [1:0], 2, [6:4], 12 and 15 through 20. Other bits read back as 0. Reads of offset 0x00 return the stored word. The read data is 0 whenever no read is in progress.
- R3: The character length output equals 5 plus control [1:0]. The stop-bit output follows bit 2. Bits 12, 15, 16, 17 and 20 drive, in turn, the flow-control, port-enable, receive-DMA-enable, transmit-DMA-enable and loopback outputs.
- R4: Parity field [6:4] decodes as follows. 4 is odd. 5 is a stuck-one (mark) bit. 6 is even. 7 is a stuck-zero (space) bit. Values 0 to 3 give no parity. The outputs are parity enable, stick, and odd-or-mark.
- R5: A write to offset 0x08 pushes data bits [7:0] in the same cycle if the transmit FIFO is not full. If the FIFO is full, nothing is pushed and status bit 3 is set on the next cycle.
- R6: A read of offset 0x04 returns the head byte zero-extended and pops it in the same cycle. When the receive FIFO is empty the read returns 0 and does not pop.
- R7: Status bit 0 is set on the cycle after the receive FIFO is non-empty. Writing 1 to status bit 0 clears it, unless the set condition holds in that same cycle, in which case the flag stays set.
- R8: Status bit 1 is set on the cycle after the transmit fill level is below half the depth. It is cleared and given priority in the same way as bit 0.
- R9: A pulse on the overrun input sets status bit 2 on the next cycle. Bits 2 and 3 clear when a 1 is written to them, and a new event in the same cycle wins over the clear.
- R10: Status also reports live inputs in these positions: bit 4 receive error, bit 5 receive empty, bit 6 transmit full, bit 7 CTS, bit 8 RTS, bit 10 transmit empty, and [16:11] the transmit level. All other bits are 0.
- R11: The interrupt output is high when the receive pending flag is set and control bit 18 is set, or when the transmit pending flag is set and control bit 19 is set.
- R12: Reads of offset 0x08 return 0. Writes to offset 0x04 pop nothing. Status bits above 3 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_byte | output | 8 | Byte pushed into transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_byte | input | 8 | Receive FIFO head byte |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_bad | input | 1 | Head byte had a framing or parity error |
| rx_overrun | input | 1 | Receive overrun event pulse |
| cts_in | input | 1 | CTS line state |
| rts_state | input | 1 | Current RTS output state |
| cfg_data_bits | output | 4 | Character length, 5 to 8 |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_par_en | output | 1 | Parity bit present |
| cfg_par_stick | output | 1 | Parity bit has a fixed value |
| cfg_par_odd | output | 1 | Odd parity, or a fixed one |
| cfg_flow_en | output | 1 | Hardware flow control enable |
| cfg_port_en | output | 1 | Port enable |
| cfg_rx_dma_en | output | 1 | Receive DMA request enable |
| cfg_tx_dma_en | output | 1 | Transmit DMA request enable |
| cfg_loopback | output | 1 | Internal loopback enable |
| irq | output | 1 | Interrupt request level |

## Verification
Several same-cycle collisions matter here. A write of ones to the status word can meet the condition that sets the same flag. This happens with a receive byte still waiting, or with the overrun pulse arriving in the clearing write's own cycle. A third collision is a transmit write that lands while the FIFO is full. The bench drives each collision on purpose. A behavioural reference model is updated at every clock from the same stimulus and is compared against the status read-back and the interrupt output. The set is expected to win in each collision, and a full-FIFO write must raise the error flag without producing a push.

// File: rtl/sport_regs.sv
`timescale 1ns/1ps
module sport_regs #(
  parameter int TX_DEPTH = 32,
  parameter int ADDR_W = 4,
  localparam int LVL_W = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic [LVL_W-1:0]  tx_level,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              rx_empty,
  input  logic              rx_bad,
  input  logic              rx_overrun,
  input  logic              cts_in,
  input  logic              rts_state,
  output logic [3:0]        cfg_data_bits,
  output logic              cfg_two_stop,
  output logic              cfg_par_en,
  output logic              cfg_par_stick,
  output logic              cfg_par_odd,
  output logic              cfg_flow_en,
  output logic              cfg_port_en,
  output logic              cfg_rx_dma_en,
  output logic              cfg_tx_dma_en,
  output logic              cfg_loopback,
  output logic              irq
);
  localparam logic [31:0] CTL_MASK = 32'h001F_9077;
  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(TX_DEPTH / 2);

  logic [31:0] ctl_q;
  logic rx_pend_q, tx_pend_q, ovr_q, terr_q;
  logic [1:0] reg_sel;
  logic wr_ctl, wr_tx, wr_st, rd_any;
  logic [5:0] lvl_field;
  logic [31:0] stat;
  logic unused_addr;

  assign reg_sel = bus_addr[3:2];
  assign wr_ctl = bus_en & bus_we & (reg_sel == 2'd0);
  assign wr_tx  = bus_en & bus_we & (reg_sel == 2'd2);
  assign wr_st  = bus_en & bus_we & (reg_sel == 2'd3);
  assign rd_any = bus_en & ~bus_we;
  assign unused_addr = ^bus_addr;

  assign tx_push = wr_tx & ~tx_full;
  assign tx_byte = bus_wdata[7:0];
  assign rx_pop  = rd_any & (reg_sel == 2'd1) & ~rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      rx_pend_q <= 1'b0;
      tx_pend_q <= 1'b0;
      ovr_q     <= 1'b0;
      terr_q    <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata & CTL_MASK;
      rx_pend_q <= ~rx_empty | (rx_pend_q & ~(wr_st & bus_wdata[0]));
      tx_pend_q <= (tx_level < HALF_L) | (tx_pend_q & ~(wr_st & bus_wdata[1]));
      ovr_q     <= rx_overrun | (ovr_q & ~(wr_st & bus_wdata[2]));
      terr_q    <= (wr_tx & tx_full) | (terr_q & ~(wr_st & bus_wdata[3]));
    end
  end

  assign lvl_field = 6'(tx_level);
  assign stat = {15'b0, lvl_field, tx_empty, 1'b0, rts_state, cts_in, tx_full,
                 rx_empty, rx_bad, terr_q, ovr_q, tx_pend_q, rx_pend_q};

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (reg_sel)
        2'd0: bus_rdata = ctl_q;
        2'd1: bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_byte};
        2'd2: bus_rdata = 32'd0;
        default: bus_rdata = stat;
      endcase
    end
  end

  assign cfg_data_bits = 4'd5 + {2'b00, ctl_q[1:0]};
  assign cfg_two_stop  = ctl_q[2];
  assign cfg_par_en    = ctl_q[6];
  assign cfg_par_stick = ctl_q[6] & ctl_q[4];
  assign cfg_par_odd   = ctl_q[6] & ~ctl_q[5];
  assign cfg_flow_en   = ctl_q[12];
  assign cfg_port_en   = ctl_q[15];
  assign cfg_rx_dma_en = ctl_q[16];
  assign cfg_tx_dma_en = ctl_q[17];
  assign cfg_loopback  = ctl_q[20];
  assign irq = (rx_pend_q & ctl_q[18]) | (tx_pend_q & ctl_q[19]);
endmodule

// File: rtl/sport_regs_chk.sv
`timescale 1ns/1ps
module sport_regs_chk #(
  parameter int TX_DEPTH = 32,
  parameter int ADDR_W = 4,
  localparam int LVL_W = $clog2(TX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tx_full,
  input logic              tx_push,
  input logic [LVL_W-1:0]  tx_level,
  input logic              rx_empty,
  input logic              rx_pop,
  input logic              rx_overrun,
  input logic              rx_pend_q,
  input logic              tx_pend_q,
  input logic              ovr_q,
  input logic              irq
);
  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(TX_DEPTH / 2);
  logic clr_rx;
  assign clr_rx = bus_en & bus_we & (bus_addr[3:2] == 2'd3) & bus_wdata[0];

  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_push);
  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_pop);
  a_r7_rx_pend_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_empty |=> rx_pend_q);
  a_r7_rx_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx && rx_empty) |=> !rx_pend_q);
  a_r8_tx_pend_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < HALF_L) |=> tx_pend_q);
  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> ovr_q);
  a_r11_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_pend_q || tx_pend_q));
endmodule

bind sport_regs sport_regs_chk #(.TX_DEPTH(TX_DEPTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sport_regs_tb.sv
`timescale 1ns/1ps
module sport_regs_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int RXCAP = 16;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tx_push, tx_full = 0, tx_empty = 1;
  logic [7:0] tx_byte, rx_byte = 0;
  logic [5:0] tx_level = 0;
  logic rx_pop, rx_empty = 1, rx_bad = 0, rx_overrun = 0, cts_in = 0, rts_state = 0;
  logic [3:0] cfg_data_bits;
  logic cfg_two_stop, cfg_par_en, cfg_par_stick, cfg_par_odd, cfg_flow_en, cfg_port_en;
  logic cfg_rx_dma_en, cfg_tx_dma_en, cfg_loopback, irq;

  sport_regs u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_ctl = 0;
  bit m_rxp = 0, m_txp = 0, m_ovr = 0, m_terr = 0;
  logic [7:0] rxq[$], txq[$], sent[$];

  bit s_en, s_we, s_rxin_v, s_drain, s_ovr, s_bad, s_cts, s_rts;
  logic [3:0] s_addr;
  logic [31:0] s_wdata;
  logic [7:0] s_rxin_b;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    s_en = 0; s_we = 0; s_addr = 0; s_wdata = 0; s_rxin_v = 0; s_rxin_b = 0;
    s_drain = 0; s_ovr = 0;
  endtask

  task automatic step();
    logic [31:0] e_rd, e_stat;
    bit e_push, e_pop, e_pen, e_pst, e_pod, wst;
    @(negedge clk);
    bus_en = s_en; bus_we = s_we; bus_addr = s_addr; bus_wdata = s_wdata;
    rx_overrun = s_ovr; rx_bad = s_bad; cts_in = s_cts; rts_state = s_rts;
    rx_empty = (rxq.size() == 0); rx_byte = rx_empty ? 8'h00 : rxq[0];
    tx_full = (txq.size() >= DEPTH); tx_empty = (txq.size() == 0);
    tx_level = 6'(txq.size());
    #1;
    e_stat = 0;
    e_stat[0] = m_rxp; e_stat[1] = m_txp; e_stat[2] = m_ovr; e_stat[3] = m_terr;
    e_stat[4] = s_bad; e_stat[5] = rx_empty; e_stat[6] = tx_full; e_stat[7] = s_cts;
    e_stat[8] = s_rts; e_stat[10] = tx_empty; e_stat[16:11] = 6'(txq.size());
    e_rd = 0;
    if (s_en && !s_we) begin
      if (s_addr[3:2] == 0) e_rd = m_ctl;
      else if (s_addr[3:2] == 1) e_rd = rx_empty ? 0 : {24'd0, rxq[0]};
      else if (s_addr[3:2] == 3) e_rd = e_stat;
    end
    e_push = s_en && s_we && s_addr[3:2] == 2 && txq.size() < DEPTH;
    e_pop  = s_en && !s_we && s_addr[3:2] == 1 && rxq.size() != 0;
    case (m_ctl[6:4])
      3'd4: begin e_pen = 1; e_pst = 0; e_pod = 1; end
      3'd5: begin e_pen = 1; e_pst = 1; e_pod = 1; end
      3'd6: begin e_pen = 1; e_pst = 0; e_pod = 0; end
      3'd7: begin e_pen = 1; e_pst = 1; e_pod = 0; end
      default: begin e_pen = 0; e_pst = 0; e_pod = 0; end
    endcase
    cmp("R2/R6/R10/R12 rdata", bus_rdata, e_rd);
    cmp("R5/R12 tx_push", 32'(tx_push), 32'(e_push));
    if (e_push) cmp("R5 tx_byte", 32'(tx_byte), 32'(s_wdata[7:0]));
    cmp("R6/R12 rx_pop", 32'(rx_pop), 32'(e_pop));
    cmp("R3 data_bits", 32'(cfg_data_bits), 5 + 32'(m_ctl[1:0]));
    cmp("R3 misc cfg", {cfg_two_stop, cfg_flow_en, cfg_port_en, cfg_rx_dma_en, cfg_tx_dma_en, cfg_loopback},
        {m_ctl[2], m_ctl[12], m_ctl[15], m_ctl[16], m_ctl[17], m_ctl[20]});
    cmp("R4 parity", {cfg_par_en, cfg_par_stick, cfg_par_odd}, {e_pen, e_pst, e_pod});
    cmp("R11 irq", 32'(irq), 32'((m_rxp && m_ctl[18]) || (m_txp && m_ctl[19])));
    @(posedge clk);
    wst = s_en && s_we && s_addr[3:2] == 3;
    if (s_en && s_we && s_addr[3:2] == 0) m_ctl = s_wdata & 32'h001F_9077;
    m_rxp = (rxq.size() != 0) || (m_rxp && !(wst && s_wdata[0]));
    m_txp = (txq.size() < DEPTH/2) || (m_txp && !(wst && s_wdata[1]));
    m_ovr = s_ovr || (m_ovr && !(wst && s_wdata[2]));
    m_terr = (s_en && s_we && s_addr[3:2] == 2 && txq.size() >= DEPTH) || (m_terr && !(wst && s_wdata[3]));
    if (e_pop) void'(rxq.pop_front());
    if (e_push) txq.push_back(s_wdata[7:0]);
    if (s_rxin_v && rxq.size() < RXCAP) rxq.push_back(s_rxin_b);
    if (s_drain && txq.size() > 0) sent.push_back(txq.pop_front());
    clear_stim();
  endtask

  task automatic bw(logic [3:0] a, logic [31:0] d);
    s_en = 1; s_we = 1; s_addr = a; s_wdata = d; step();
  endtask
  task automatic br(logic [3:0] a);
    s_en = 1; s_we = 0; s_addr = a; step();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (R1..) act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_stim(); s_bad = 0; s_cts = 0; s_rts = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    br(4'h0); br(4'hC);
    // R2 mask and readback
    bw(4'h0, 32'hFFFF_FFFF); br(4'h0);
    bw(4'h0, 32'h0); br(4'h0);
    // R3, R4 every length and parity code
    for (int p = 0; p < 8; p++)
      for (int l = 0; l < 4; l++) begin
        bw(4'h0, (p << 4) | l | ((l & 1) << 2) | ((p & 1) << 12) | ((l & 2) << 14) | (1 << 20));
        br(4'h0);
      end
    // R11 enables
    bw(4'h0, (1 << 18) | (1 << 19)); br(4'hC);
    // R8 clear collides with set condition
    bw(4'hC, 32'h2); br(4'hC);
    // R5 fill FIFO, then one extra write on full
    for (int i = 0; i < DEPTH + 1; i++) bw(4'h8, 32'h100 + i);
    br(4'hC); br(4'h8);
    bw(4'hC, 32'h2); br(4'hC);
    bw(4'hC, 32'h8); br(4'hC);
    // drain below half, R8 sets again
    for (int i = 0; i < DEPTH; i++) begin s_drain = 1; step(); end
    br(4'hC);
    for (int i = 0; i < DEPTH; i++) cmp("R5 byte order", 32'(sent[i]), 32'(8'(i)));
    bw(4'hC, 32'h0);
    bw(4'h0, 32'h1 << 18);
    // R6 receive path
    s_rxin_v = 1; s_rxin_b = 8'hA5; step();
    s_rxin_v = 1; s_rxin_b = 8'h3C; step();
    s_rxin_v = 1; s_rxin_b = 8'hFF; step();
    br(4'hC);
    bw(4'h4, 32'h55); // R12 no pop
    br(4'h4); br(4'h4); br(4'h4); br(4'h4);
    br(4'hC);
    // R7 clear while data still present: stays set
    s_rxin_v = 1; s_rxin_b = 8'h11; step();
    bw(4'hC, 32'h1); br(4'hC);
    br(4'h4); step();
    bw(4'hC, 32'h1); br(4'hC);
    // R9 overrun and clear in same cycle
    s_ovr = 1; step();
    s_ovr = 1; s_en = 1; s_we = 1; s_addr = 4'hC; s_wdata = 32'h4; step();
    br(4'hC);
    bw(4'hC, 32'h4); br(4'hC);
    // R10 live inputs, R12 upper status bits not writable
    s_bad = 1; s_cts = 1; br(4'hC);
    s_rts = 1; s_cts = 0; br(4'hC);
    bw(4'hC, 32'hFFFF_FFF0); br(4'hC);
    s_bad = 0; s_rts = 0; br(4'hC);
    bw(4'hC, 32'hF); br(4'hC);
    repeat (3) step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule